// File: doc/BRIEF.md
# Block-Circular Pulse-Shaping Filter Engine

This engine performs the filtering stage of a GFDM transmitter in the time domain. The input is M vectors of K complex fixed-point samples each, already produced by an inverse transform. The engine holds these vectors in a local data store. A tap store holds N = M·K complex pulse-shape coefficients. After a start pulse, the engine multiplies and accumulates samples against the circularly indexed taps. It then streams out the N filtered samples in index order.

The filter wraps circularly over whole vectors. Output element i of vector l combines element i of every input vector m with tap ((l−m) mod M)·K + i. The engine does not compute that modulo by division. A base counter starts at l·K, steps down by K per input vector, and reloads to (M−1)·K when it would pass below zero. Loading a second tap set that inverts the first filtering lets the same engine serve the receive side.

Top module: `blkcirc_filter`

## Requirements
- R1: Both store write ports report ready only while the engine is idle, and a write is taken only when valid and ready are both high. A write offered while busy changes neither store.
- R2: A start pulse begins a block only when the engine is idle. A start pulse seen while busy has no effect, so no second block follows the running one.
- R3: Output n = l·K+i equals the sum over m = 0..M−1 of g[((l−m) mod M)·K+i] · D[m·K+i], computed as complex products. The real part is gr·dr − gi·di and the imaginary part is gr·di + gi·dr. Data sample j and tap j sit at store address j.
- R4: Each block emits exactly N samples, in increasing order of n.
- R5: Each accumulator is scaled back by DATA_W−1 fractional bits. Rounding is to nearest, with halves going away from zero: +0.5 LSB becomes +1 and −0.5 LSB becomes −1.
- R6: A rounded result outside the signed DATA_W range is clamped to the largest or the smallest code.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_re and out_im hold their values. No sample is lost or repeated.
- R8: done is a one-cycle pulse in the cycle after the last sample is accepted. In that cycle busy and out_valid are both low.
- R9: With out_ready held high, busy stays high for exactly M·(M·K+K) cycles per block. This is M·K multiply-accumulate cycles and K output cycles for each output vector.
- R10: Both stores keep their contents across blocks. A second start with no writes in between gives identical outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dat_wr_valid | input | 1 | Data store write request |
| dat_wr_ready | output | 1 | Data store accepts writes (idle) |
| dat_wr_addr | input | AW | Data sample address m·K+i |
| dat_wr_re | input | DATA_W | Data real part, signed Q0.(DATA_W−1) |
| dat_wr_im | input | DATA_W | Data imaginary part |
| tap_wr_valid | input | 1 | Tap store write request |
| tap_wr_ready | output | 1 | Tap store accepts writes (idle) |
| tap_wr_addr | input | AW | Tap address |
| tap_wr_re | input | DATA_W | Tap real part |
| tap_wr_im | input | DATA_W | Tap imaginary part |
| start | input | 1 | Begin a block (honoured when idle) |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle end-of-block pulse |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Output sample accepted |
| out_re | output | DATA_W | Output real part |
| out_im | output | DATA_W | Output imaginary part |

## Verification
On every cycle, the assertions check the stream and the control rules. Held data must stay stable under back-pressure, done must be a single pulse with the engine idle, exactly N handshakes must occur per block, and a start at idle must begin a block. Only the bench scenarios can show that the values are correct. This covers the circular tap selection for each (l, m), rounding of exact half-LSB sums in both signs, clamping at both ends, and identical results across repeated blocks. It also covers the exact busy length, and the absence of effect from writes and starts offered while busy.

// File: rtl/blkcirc_pkg.sv
package blkcirc_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_MAC  = 2'd1,
      SQ_EMIT = 2'd2
   } seq_state_t;
endpackage

// File: rtl/blkcirc_seq.sv
module blkcirc_seq
   import blkcirc_pkg::*;
#(
   parameter int M = 4,
   parameter int K = 8
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   start_i,
   input  logic                                   out_ready_i,
   output logic                                   busy_o,
   output logic                                   mac_en_o,
   output logic                                   first_o,
   output logic [((K > 1) ? $clog2(K) : 1)-1:0]   lane_o,
   output logic [((M*K > 1) ? $clog2(M*K) : 1)-1:0] d_addr_o,
   output logic [((M*K > 1) ? $clog2(M*K) : 1)-1:0] g_addr_o,
   output logic                                   emit_valid_o,
   output logic                                   done_o
);
   localparam int N    = M * K;
   localparam int AW   = (N > 1) ? $clog2(N) : 1;
   localparam int KW   = (K > 1) ? $clog2(K) : 1;
   localparam int MW   = (M > 1) ? $clog2(M) : 1;
   localparam logic [AW-1:0] STEP = AW'(K);
   localparam logic [AW-1:0] WRAP = AW'((M - 1) * K);

   seq_state_t    st;
   logic [KW-1:0] lane;
   logic [MW-1:0] vec;
   logic [MW-1:0] row;
   logic [AW-1:0] d_base, t_base, l_base;
   logic          done_q;

   wire lane_last = (lane == KW'(K - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         lane   <= '0;
         vec    <= '0;
         row    <= '0;
         d_base <= '0;
         t_base <= '0;
         l_base <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            SQ_IDLE: begin
               if (start_i) begin
                  st     <= SQ_MAC;
                  lane   <= '0;
                  vec    <= '0;
                  row    <= '0;
                  d_base <= '0;
                  t_base <= '0;
                  l_base <= '0;
               end
            end
            SQ_MAC: begin
               if (lane_last) begin
                  lane <= '0;
                  if (vec == MW'(M - 1)) begin
                     vec <= '0;
                     st  <= SQ_EMIT;
                  end else begin
                     vec    <= vec + MW'(1);
                     d_base <= d_base + STEP;
                     // circular step: below zero reloads to the last vector base
                     t_base <= (t_base == '0) ? WRAP : t_base - STEP;
                  end
               end else begin
                  lane <= lane + KW'(1);
               end
            end
            SQ_EMIT: begin
               if (out_ready_i) begin
                  if (lane_last) begin
                     lane <= '0;
                     if (row == MW'(M - 1)) begin
                        st     <= SQ_IDLE;
                        done_q <= 1'b1;
                     end else begin
                        row    <= row + MW'(1);
                        l_base <= l_base + STEP;
                        t_base <= l_base + STEP;
                        d_base <= '0;
                        st     <= SQ_MAC;
                     end
                  end else begin
                     lane <= lane + KW'(1);
                  end
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign busy_o       = (st != SQ_IDLE);
   assign mac_en_o     = (st == SQ_MAC);
   assign emit_valid_o = (st == SQ_EMIT);
   assign first_o      = (vec == '0);
   assign lane_o       = lane;
   assign d_addr_o     = d_base + AW'(lane);
   assign g_addr_o     = t_base + AW'(lane);
   assign done_o       = done_q;
endmodule

// File: rtl/blkcirc_accbank.sv
module blkcirc_accbank #(
   parameter int K      = 8,
   parameter int DATA_W = 16,
   parameter int ACC_W  = 40
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 mac_en_i,
   input  logic                                 first_i,
   input  logic [((K > 1) ? $clog2(K) : 1)-1:0] lane_i,
   input  logic signed [DATA_W-1:0]             g_re_i,
   input  logic signed [DATA_W-1:0]             g_im_i,
   input  logic signed [DATA_W-1:0]             d_re_i,
   input  logic signed [DATA_W-1:0]             d_im_i,
   output logic signed [ACC_W-1:0]              acc_re_o,
   output logic signed [ACC_W-1:0]              acc_im_o
);
   localparam int KW = (K > 1) ? $clog2(K) : 1;
   localparam int PW = 2 * DATA_W;

   logic signed [PW-1:0]    p_rr, p_ii, p_ri, p_ir;
   logic signed [ACC_W-1:0] mac_re, mac_im;
   logic signed [ACC_W-1:0] acc_re [K];
   logic signed [ACC_W-1:0] acc_im [K];

   assign p_rr   = g_re_i * d_re_i;
   assign p_ii   = g_im_i * d_im_i;
   assign p_ri   = g_re_i * d_im_i;
   assign p_ir   = g_im_i * d_re_i;
   assign mac_re = ACC_W'(p_rr) - ACC_W'(p_ii);
   assign mac_im = ACC_W'(p_ri) + ACC_W'(p_ir);

   for (genvar k = 0; k < K; k++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_re[k] <= '0;
            acc_im[k] <= '0;
         end else if (mac_en_i && (lane_i == KW'(k))) begin
            acc_re[k] <= (first_i ? '0 : acc_re[k]) + mac_re;
            acc_im[k] <= (first_i ? '0 : acc_im[k]) + mac_im;
         end
      end
   end

   assign acc_re_o = acc_re[lane_i];
   assign acc_im_o = acc_im[lane_i];
endmodule

// File: rtl/blkcirc_rndsat.sv
module blkcirc_rndsat #(
   parameter int IN_W  = 40,
   parameter int OUT_W = 16,
   parameter int FRAC  = 15
) (
   input  logic signed [IN_W-1:0]  val_i,
   output logic signed [OUT_W-1:0] val_o
);
   localparam int EW = IN_W + 1;
   localparam logic signed [EW-1:0] MAXV = EW'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
   localparam logic signed [EW-1:0] MINV = -MAXV - EW'(1);

   logic signed [EW-1:0] ext, scaled;
   assign ext = EW'(val_i);

   if (FRAC > 0) begin : g_round
      localparam logic signed [EW-1:0] HALF = EW'(64'sd1 <<< (FRAC - 1));
      logic signed [EW-1:0] biased;
      // negative values take one less bias so exact halves move away from zero
      assign biased = ext + (val_i[IN_W-1] ? HALF - EW'(1) : HALF);
      assign scaled = biased >>> FRAC;
   end else begin : g_pass
      assign scaled = ext;
   end

   assign val_o = (scaled > MAXV) ? OUT_W'(MAXV) :
                  (scaled < MINV) ? OUT_W'(MINV) : OUT_W'(scaled);
endmodule

// File: rtl/blkcirc_filter.sv
module blkcirc_filter #(
   parameter int M      = 4,
   parameter int K      = 8,
   parameter int DATA_W = 16,
   parameter int ACC_W  = 40
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     dat_wr_valid,
   output logic                                     dat_wr_ready,
   input  logic [((M*K > 1) ? $clog2(M*K) : 1)-1:0] dat_wr_addr,
   input  logic signed [DATA_W-1:0]                 dat_wr_re,
   input  logic signed [DATA_W-1:0]                 dat_wr_im,
   input  logic                                     tap_wr_valid,
   output logic                                     tap_wr_ready,
   input  logic [((M*K > 1) ? $clog2(M*K) : 1)-1:0] tap_wr_addr,
   input  logic signed [DATA_W-1:0]                 tap_wr_re,
   input  logic signed [DATA_W-1:0]                 tap_wr_im,
   input  logic                                     start,
   output logic                                     busy,
   output logic                                     done,
   output logic                                     out_valid,
   input  logic                                     out_ready,
   output logic signed [DATA_W-1:0]                 out_re,
   output logic signed [DATA_W-1:0]                 out_im
);
   localparam int N  = M * K;
   localparam int AW = (N > 1) ? $clog2(N) : 1;
   localparam int KW = (K > 1) ? $clog2(K) : 1;

   if (M < 1 || K < 1) begin : g_bad_dims
      $error("blkcirc_filter: M and K must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("blkcirc_filter: DATA_W must be at least 2");
   end
   if (ACC_W < 2 * DATA_W + 1) begin : g_bad_acc
      $error("blkcirc_filter: ACC_W must hold a full complex product sum");
   end

   logic signed [DATA_W-1:0] dmem_re [N];
   logic signed [DATA_W-1:0] dmem_im [N];
   logic signed [DATA_W-1:0] gmem_re [N];
   logic signed [DATA_W-1:0] gmem_im [N];

   logic                    mac_en, first;
   logic [KW-1:0]           lane;
   logic [AW-1:0]           d_addr, g_addr;
   logic signed [ACC_W-1:0] acc_re, acc_im;

   assign dat_wr_ready = !busy;
   assign tap_wr_ready = !busy;

   always_ff @(posedge clk) begin
      if (dat_wr_valid && dat_wr_ready && (32'(dat_wr_addr) < N)) begin
         dmem_re[dat_wr_addr] <= dat_wr_re;
         dmem_im[dat_wr_addr] <= dat_wr_im;
      end
      if (tap_wr_valid && tap_wr_ready && (32'(tap_wr_addr) < N)) begin
         gmem_re[tap_wr_addr] <= tap_wr_re;
         gmem_im[tap_wr_addr] <= tap_wr_im;
      end
   end

   blkcirc_seq #(.M(M), .K(K)) seq_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start),
      .out_ready_i  (out_ready),
      .busy_o       (busy),
      .mac_en_o     (mac_en),
      .first_o      (first),
      .lane_o       (lane),
      .d_addr_o     (d_addr),
      .g_addr_o     (g_addr),
      .emit_valid_o (out_valid),
      .done_o       (done)
   );

   blkcirc_accbank #(.K(K), .DATA_W(DATA_W), .ACC_W(ACC_W)) acc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .mac_en_i (mac_en),
      .first_i  (first),
      .lane_i   (lane),
      .g_re_i   (gmem_re[g_addr]),
      .g_im_i   (gmem_im[g_addr]),
      .d_re_i   (dmem_re[d_addr]),
      .d_im_i   (dmem_im[d_addr]),
      .acc_re_o (acc_re),
      .acc_im_o (acc_im)
   );

   blkcirc_rndsat #(.IN_W(ACC_W), .OUT_W(DATA_W), .FRAC(DATA_W - 1)) rs_re_i (
      .val_i (acc_re),
      .val_o (out_re)
   );

   blkcirc_rndsat #(.IN_W(ACC_W), .OUT_W(DATA_W), .FRAC(DATA_W - 1)) rs_im_i (
      .val_i (acc_im),
      .val_o (out_im)
   );
endmodule

// File: rtl/blkcirc_chk.sv
module blkcirc_chk #(
   parameter int M      = 4,
   parameter int K      = 8,
   parameter int DATA_W = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     dat_wr_ready,
   input logic                     tap_wr_ready,
   input logic                     start,
   input logic                     busy,
   input logic                     done,
   input logic                     out_valid,
   input logic                     out_ready,
   input logic signed [DATA_W-1:0] out_re,
   input logic signed [DATA_W-1:0] out_im
);
   localparam int N = M * K;

   int hs_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   hs_cnt <= 0;
      else if (start && !busy)      hs_cnt <= 0;
      else if (out_valid && out_ready) hs_cnt <= hs_cnt + 1;
   end

   p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (!dat_wr_ready && !tap_wr_ready));

   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && dat_wr_ready) |=> busy);

   p_valid_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> busy);

   p_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (hs_cnt == N));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !out_valid));
endmodule

bind blkcirc_filter blkcirc_chk #(.M(M), .K(K), .DATA_W(DATA_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .dat_wr_ready (dat_wr_ready),
   .tap_wr_ready (tap_wr_ready),
   .start        (start),
   .busy         (busy),
   .done         (done),
   .out_valid    (out_valid),
   .out_ready    (out_ready),
   .out_re       (out_re),
   .out_im       (out_im)
);

// File: tb/blkcirc_filter_tb_top.sv
`timescale 1ns/1ps
module blkcirc_filter_tb_top;
   localparam int M      = 3;
   localparam int K      = 5;
   localparam int DATA_W = 12;
   localparam int ACC_W  = 32;
   localparam int N      = M * K;
   localparam int AW     = (N > 1) ? $clog2(N) : 1;
   localparam int FRAC   = DATA_W - 1;
   localparam int DMAX   = (1 << (DATA_W - 1)) - 1;
   localparam int DMIN   = -(1 << (DATA_W - 1));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dat_wr_valid = 1'b0, tap_wr_valid = 1'b0;
   logic [AW-1:0] dat_wr_addr = '0, tap_wr_addr = '0;
   logic signed [DATA_W-1:0] dat_wr_re = '0, dat_wr_im = '0, tap_wr_re = '0, tap_wr_im = '0;
   logic start = 1'b0, out_ready = 1'b0;
   logic dat_wr_ready, tap_wr_ready, busy, done, out_valid;
   logic signed [DATA_W-1:0] out_re, out_im;

   always #10 clk = ~clk;

   blkcirc_filter #(.M(M), .K(K), .DATA_W(DATA_W), .ACC_W(ACC_W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .dat_wr_valid(dat_wr_valid), .dat_wr_ready(dat_wr_ready), .dat_wr_addr(dat_wr_addr),
      .dat_wr_re(dat_wr_re), .dat_wr_im(dat_wr_im),
      .tap_wr_valid(tap_wr_valid), .tap_wr_ready(tap_wr_ready), .tap_wr_addr(tap_wr_addr),
      .tap_wr_re(tap_wr_re), .tap_wr_im(tap_wr_im),
      .start(start), .busy(busy), .done(done),
      .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re), .out_im(out_im)
   );

   int checks = 0;
   int errors = 0;
   int dr[N], di[N], gr[N], gi[N];
   int er[N], ei[N];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int rnd_sample();
      return int'($urandom % 32'd4096) - 2048;
   endfunction

   function automatic int round_sat(input longint s);
      longint half = longint'(1) <<< (FRAC - 1);
      longint r;
      if (s >= 0) r = (s + half) >>> FRAC;
      else        r = -((-s + half) >>> FRAC);
      if (r > DMAX) r = DMAX;
      if (r < DMIN) r = DMIN;
      return int'(r);
   endfunction

   task automatic model();
      for (int l = 0; l < M; l++) begin
         for (int i = 0; i < K; i++) begin
            longint sr = 0, si = 0;
            for (int m = 0; m < M; m++) begin
               int t = ((l - m + M) % M) * K + i;
               int d = m * K + i;
               sr += longint'(gr[t]) * dr[d] - longint'(gi[t]) * di[d];
               si += longint'(gr[t]) * di[d] + longint'(gi[t]) * dr[d];
            end
            er[l*K+i] = round_sat(sr);
            ei[l*K+i] = round_sat(si);
         end
      end
   endtask

   task automatic load_stores(input bit do_dat, input bit do_tap);
      for (int n = 0; n < N; n++) begin
         @(negedge clk);
         dat_wr_valid = do_dat; dat_wr_addr = AW'(n);
         dat_wr_re = DATA_W'(dr[n]); dat_wr_im = DATA_W'(di[n]);
         tap_wr_valid = do_tap; tap_wr_addr = AW'(n);
         tap_wr_re = DATA_W'(gr[n]); tap_wr_im = DATA_W'(gi[n]);
      end
      @(negedge clk);
      dat_wr_valid = 1'b0; tap_wr_valid = 1'b0;
   endtask

   task automatic run_block(input bit bp, input bit poke, input string req);
      int idx = 0, bc = 0, it = 0;
      bit stall = 0;
      int pre = 0, pim = 0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      forever begin
         if (busy) bc++;
         if (done) break;
         if (stall) begin
            chk(out_valid && int'(out_re) == pre && int'(out_im) == pim, "R7 held sample",
                int'(out_re), pre);
         end
         if (poke && it == 7) begin
            start = 1'b1;
            dat_wr_valid = 1'b1; dat_wr_addr = '0; dat_wr_re = 12'sd777; dat_wr_im = -12'sd5;
            tap_wr_valid = 1'b1; tap_wr_addr = '0; tap_wr_re = 12'sd777; tap_wr_im = 12'sd9;
            chk(!dat_wr_ready && !tap_wr_ready, "R1 ready low while busy", int'(dat_wr_ready), 0);
         end else begin
            start = 1'b0; dat_wr_valid = 1'b0; tap_wr_valid = 1'b0;
         end
         out_ready = bp ? 1'($urandom % 2) : 1'b1;
         if (out_valid && out_ready) begin
            if (idx < N) begin
               chk(int'(out_re) == er[idx], {req, " real"}, int'(out_re), er[idx]);
               chk(int'(out_im) == ei[idx], {req, " imag"}, int'(out_im), ei[idx]);
            end
            idx++;
         end
         stall = out_valid && !out_ready;
         pre = int'(out_re); pim = int'(out_im);
         @(negedge clk);
         it++;
         if (it > 20000) begin
            chk(0, "watchdog block", it, 0);
            break;
         end
      end
      start = 1'b0; dat_wr_valid = 1'b0; tap_wr_valid = 1'b0; out_ready = 1'b0;
      chk(idx == N, "R4 sample count", idx, N);
      chk(!busy && !out_valid, "R8 idle at done", int'(busy), 0);
      if (!bp) chk(bc == M * (M * K + K), "R9 busy length", bc, M * (M * K + K));
      @(negedge clk);
      chk(!done, "R8 done single pulse", int'(done), 0);
      repeat (3) @(negedge clk);
      chk(!busy, "R2 no extra block", int'(busy), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd24680));
      repeat (3) @(negedge clk);
      chk(!busy && !done && !out_valid, "R8 reset idle", int'(busy), 0);
      chk(dat_wr_ready && tap_wr_ready, "R1 ready at idle", int'(dat_wr_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);

      // random stores, free-running output: values and exact busy length
      for (int n = 0; n < N; n++) begin
         dr[n] = rnd_sample(); di[n] = rnd_sample();
         gr[n] = rnd_sample() / 4; gi[n] = rnd_sample() / 4;
      end
      model();
      load_stores(1, 1);
      run_block(0, 0, "R3 random");
      // same stores under random back-pressure
      run_block(1, 0, "R7 back-pressure");

      // second tap set, with writes and a start offered mid-block
      for (int n = 0; n < N; n++) begin
         gr[n] = rnd_sample(); gi[n] = rnd_sample();
      end
      model();
      load_stores(0, 1);
      run_block(1, 1, "R1 R2 busy pokes");
      // no writes: identical results
      run_block(0, 0, "R10 rerun");

      // circular tap selection: one data sample at m=1, one tap
      for (int n = 0; n < N; n++) begin dr[n] = 0; di[n] = 0; gr[n] = 0; gi[n] = 0; end
      dr[K + 2] = 1000; gr[2] = 2047; gi[(M - 1) * K + 2] = -1500;
      model();
      load_stores(1, 1);
      run_block(0, 0, "R3 circular wrap");

      // exact halves and just-below halves in both signs
      for (int n = 0; n < N; n++) begin dr[n] = 0; di[n] = 0; gr[n] = 0; gi[n] = 0; end
      dr[0] = 32; di[0] = -32; gr[0] = 32;
      dr[1] = 31; di[1] = -31; gr[1] = 33;
      model();
      chk(er[0] == 1 && ei[0] == -1 && er[1] == 0 && ei[1] == 0, "R5 model halves", er[0], 1);
      load_stores(1, 1);
      run_block(0, 0, "R5 rounding");

      // clamping at both ends
      for (int n = 0; n < N; n++) begin
         dr[n] = DMAX; di[n] = DMIN; gr[n] = DMAX; gi[n] = 0;
      end
      model();
      chk(er[0] == DMAX && ei[0] == DMIN, "R6 model clamp", er[0], DMAX);
      load_stores(1, 1);
      run_block(1, 0, "R6 saturation");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule